// File: doc/BRIEF.md
# Delay-Line Code Controller with Lock Detection and Self-Gating

This block is the digital control loop of an all-digital delay-locked loop. A phase comparison between the reference clock and the delayed clock arrives once per cycle as a single decision, either late or early. The block keeps an 8-bit up/down count and presents it as the delay code for a binary-weighted delay line, where code bit k switches in a delay element worth 2^k unit steps. A late decision moves the code up one step and an early decision moves it down one step. The code stops at the ends of its range and does not wrap.

When the decisions start alternating direction, the loop is dithering around the alignment point. The block then declares lock, freezes the code and gates the clock of its own counter off. A latch samples the gating enable while the clock is low, so the gated clock has no glitches. While locked, the block keeps watching the decisions. A long run in a single direction means alignment has been lost, so lock is dropped and counting starts again.

A hold input freezes the loop. A sleep input stops the loop and keeps the code in a retention latch. On wake, the counter reloads from that latch rather than acquiring lock again from scratch.

Top module: `dll_code_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the code to mid-scale (128) and clears lock and all decision history.
- R2: With pd_valid_i high and not locked, pd_late_i = 1 (late) raises the code by one and pd_late_i = 0 (early) lowers it by one. The new code appears after the clock edge that sampled the decision. With pd_valid_i low the code does not change.
- R3: The code saturates: a late decision at 255 leaves 255, and an early decision at 0 leaves 0.
- R4: Lock asserts on the edge that takes the fourth consecutive decision whose direction differs from the decision before it. The counter still applies that decision. From then on the counter clock is gated.
- R5: With a line delay of base plus code times a unit step, feeding the decision from comparing that delay with a period whose ideal code is 100 or 200 gives lock within 110 decisions after reset. The code at lock is within one step of the ideal code.
- R6: While locked, valid decisions do not change the code, provided no run of 8 same-direction decisions has built up.
- R7: While locked, the eighth consecutive same-direction decision clears lock and does not change the code. Later decisions step the code again.
- R8: While hold_i is high, the code and the lock state stay frozen, and decisions are neither applied nor counted by the lock detector.
- R9: While sleep_i is high, the code and lock state are kept and decisions are ignored. On the first edge after sleep_i falls, the code is reloaded from the retention latch, so it is unchanged, and that cycle's decision is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pd_valid_i | input | 1 | A phase decision is present this cycle |
| pd_late_i | input | 1 | Decision direction: 1 late (raise delay), 0 early (lower delay) |
| hold_i | input | 1 | Freeze code and lock detection |
| sleep_i | input | 1 | Sleep: keep code in retention latch, ignore decisions |
| code_o | output | 8 | Binary-weighted delay code |
| lock_o | output | 1 | Phase lock indication |

## Verification
The hardest situation to reach is loss of lock. It needs a locked loop followed by an unbroken run of same-direction decisions, and a closed delay-line model would never produce such a run once it has settled. The bench therefore first closes the loop through a behavioural delay model until lock asserts. It then opens the loop and drives a directed run, checking that seven decisions leave the code frozen and the eighth drops lock. The wake cycle after sleep is reached the same way, from an unlocked mid-count state, so a lost or stepped restore would be visible.

// File: rtl/dll_ctrl_pkg.sv
package dll_ctrl_pkg;
  localparam int CODE_W     = 8;
  localparam int LOCK_ALT   = 4;
  localparam int UNLOCK_RUN = 8;

  typedef enum logic {
    DIR_EARLY = 1'b0,
    DIR_LATE  = 1'b1
  } dir_e;
endpackage

// File: rtl/dll_clk_gate.sv
module dll_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_lat;

  // enable passes only while the clock is low, so it is stable across the high phase
  always_latch begin
    if (!clk_i) en_lat = en_i;
  end

  assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/dll_code_cnt.sv
module dll_code_cnt #(
  parameter int CODE_W = dll_ctrl_pkg::CODE_W
) (
  input  logic              gclk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] load_val_i,
  input  logic              step_i,
  input  logic              up_i,
  output logic [CODE_W-1:0] cnt_o
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] TOP = '1;

  logic [CODE_W-1:0] cnt_q;

  always_ff @(posedge gclk_i) begin
    if (rst_i) begin
      cnt_q <= MID;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (step_i) begin
      if (up_i && cnt_q != TOP)       cnt_q <= cnt_q + CODE_W'(1);
      else if (!up_i && cnt_q != '0)  cnt_q <= cnt_q - CODE_W'(1);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dll_lock_det.sv
module dll_lock_det #(
  parameter int LOCK_ALT   = dll_ctrl_pkg::LOCK_ALT,
  parameter int UNLOCK_RUN = dll_ctrl_pkg::UNLOCK_RUN
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic take_i,
  input  logic late_i,
  output logic lock_o
);
  localparam int AW = (LOCK_ALT   > 1) ? $clog2(LOCK_ALT)   : 1;
  localparam int RW = (UNLOCK_RUN > 1) ? $clog2(UNLOCK_RUN) : 1;
  localparam logic [AW-1:0] ALT_LAST = AW'(LOCK_ALT - 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(UNLOCK_RUN - 1);

  logic          prev_q, have_prev_q, lock_q;
  logic [AW-1:0] alt_q;
  logic [RW-1:0] run_q;
  logic          flip;

  assign flip = have_prev_q && (late_i != prev_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q      <= 1'b0;
      have_prev_q <= 1'b0;
      lock_q      <= 1'b0;
      alt_q       <= '0;
      run_q       <= '0;
    end else if (take_i) begin
      prev_q      <= late_i;
      have_prev_q <= 1'b1;
      if (!lock_q) begin
        if (!flip) begin
          alt_q <= '0;
        end else if (alt_q == ALT_LAST) begin
          lock_q <= 1'b1;
          alt_q  <= '0;
          run_q  <= '0;
        end else begin
          alt_q <= alt_q + AW'(1);
        end
      end else begin
        if (run_q == '0 || flip) begin
          run_q <= RW'(1);
        end else if (run_q == RUN_LAST) begin
          lock_q <= 1'b0;
          run_q  <= '0;
          alt_q  <= '0;
        end else begin
          run_q <= run_q + RW'(1);
        end
      end
    end
  end

  assign lock_o = lock_q;

  // R4
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(lock_q) |-> $past(take_i));

  // R7
  lock_fall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(lock_q) |-> $past(take_i));
endmodule

// File: rtl/dll_code_ctrl.sv
module dll_code_ctrl #(
  parameter int CODE_W     = dll_ctrl_pkg::CODE_W,
  parameter int LOCK_ALT   = dll_ctrl_pkg::LOCK_ALT,
  parameter int UNLOCK_RUN = dll_ctrl_pkg::UNLOCK_RUN
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              pd_valid_i,
  input  logic              pd_late_i,
  input  logic              hold_i,
  input  logic              sleep_i,
  output logic [CODE_W-1:0] code_o,
  output logic              lock_o
);
  import dll_ctrl_pkg::*;

  logic              wake_q, lock_q, cnt_en, gclk, take;
  logic [CODE_W-1:0] cnt_q, ret_q;
  dir_e              dir;

  assign dir = pd_late_i ? DIR_LATE : DIR_EARLY;

  // one-cycle marker for the first edge after sleep ends
  always_ff @(posedge clk_i) begin
    if (rst_i) wake_q <= 1'b0;
    else       wake_q <= sleep_i;
  end

  assign take   = pd_valid_i && !hold_i && !sleep_i && !wake_q;
  assign cnt_en = rst_i || (!sleep_i && (wake_q || (!lock_q && !hold_i)));

  // retention latch: follows the count while awake, holds it through sleep
  always_latch begin
    if (!sleep_i) ret_q = cnt_q;
  end

  dll_clk_gate u_gate (
    .clk_i  (clk_i),
    .en_i   (cnt_en),
    .gclk_o (gclk)
  );

  dll_code_cnt #(.CODE_W(CODE_W)) u_cnt (
    .gclk_i     (gclk),
    .rst_i      (rst_i),
    .load_i     (wake_q),
    .load_val_i (ret_q),
    .step_i     (pd_valid_i),
    .up_i       (dir == DIR_LATE),
    .cnt_o      (cnt_q)
  );

  dll_lock_det #(.LOCK_ALT(LOCK_ALT), .UNLOCK_RUN(UNLOCK_RUN)) u_lock (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .take_i (take),
    .late_i (pd_late_i),
    .lock_o (lock_q)
  );

  assign code_o = cnt_q;
  assign lock_o = lock_q;

  // R2
  step_size_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !wake_q |=> (code_o == $past(code_o) || code_o == $past(code_o) + CODE_W'(1)
                 || code_o == $past(code_o) - CODE_W'(1)));

  // R3
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (code_o == '1) |=> (code_o != '0));

  // R6
  locked_frozen_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    lock_o |=> $stable(code_o));

  // R8
  hold_frozen_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (hold_i && !wake_q) |=> ($stable(code_o) && $stable(lock_o)));

  // R9
  sleep_frozen_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (sleep_i || wake_q) |=> ($stable(code_o) && $stable(lock_o)));
endmodule

// File: tb/dll_code_ctrl_bench.sv
module dll_code_ctrl_bench;
  localparam int BASE_PS = 1000;
  localparam int UNIT_PS = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pd_valid = 1'b0, pd_late = 1'b0, hold = 1'b0, sleep = 1'b0;
  logic [7:0] code;
  logic       lock;
  int         n_total = 0, n_fail = 0;

  always #4 clk = ~clk;

  dll_code_ctrl u_dll_code_ctrl (
    .clk_i(clk), .rst_i(rst), .pd_valid_i(pd_valid), .pd_late_i(pd_late),
    .hold_i(hold), .sleep_i(sleep), .code_o(code), .lock_o(lock)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // inputs change just after a falling edge; outputs are read at the next falling edge
  task automatic drive(input logic v, input logic l);
    pd_valid = v; pd_late = l;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; hold = 1'b0; sleep = 1'b0;
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic acquire(input int period, output int n);
    n = 0;
    while (!lock && n < 300) begin
      drive(1'b1, (BASE_PS + int'(code) * UNIT_PS) < period);
      n++;
    end
  endtask

  task automatic t_reset_and_step();
    do_reset();
    chk("R1 code after reset", code, 128);
    chk("R1 lock after reset", lock, 0);
    drive(1'b1, 1'b1); chk("R2 late step", code, 129);
    drive(1'b1, 1'b0); chk("R2 early step", code, 128);
    drive(1'b1, 1'b0); chk("R2 early step", code, 127);
    drive(1'b0, 1'b1); chk("R2 no valid", code, 127);
  endtask

  task automatic t_saturate();
    do_reset();
    repeat (140) drive(1'b1, 1'b1);
    chk("R3 top saturation", code, 255);
    chk("R3 no lock on one-way run", lock, 0);
    repeat (260) drive(1'b1, 1'b0);
    chk("R3 bottom saturation", code, 0);
  endtask

  task automatic t_acquire_and_unlock();
    int n, c;
    do_reset();
    acquire(5000, n);
    chk("R5 lock within bound (target 200)", int'(lock && n <= 110), 1);
    chk("R5 code near 200", int'(code >= 199 && code <= 201), 1);
    chk("R4 lock after alternation", lock, 1);
    c = code;
    repeat (3) begin drive(1'b1, 1'b1); drive(1'b1, 1'b0); end
    chk("R6 code frozen while locked", code, c);
    repeat (7) drive(1'b1, 1'b1);
    chk("R6 seven same still locked", lock, 1);
    chk("R6 code frozen on run", code, c);
    drive(1'b1, 1'b1);
    chk("R7 eighth same clears lock", lock, 0);
    chk("R7 unlocking decision not applied", code, c);
    drive(1'b1, 1'b1);
    chk("R7 counting resumes", code, c + 1);
  endtask

  task automatic t_acquire_low();
    int n;
    do_reset();
    acquire(3000, n);
    chk("R5 lock within bound (target 100)", int'(lock && n <= 110), 1);
    chk("R5 code near 100", int'(code >= 99 && code <= 101), 1);
  endtask

  task automatic t_hold();
    do_reset();
    repeat (3) drive(1'b1, 1'b1);
    hold = 1'b1;
    drive(1'b1, 1'b1); drive(1'b1, 1'b0); drive(1'b1, 1'b1);
    drive(1'b1, 1'b0); drive(1'b1, 1'b1);
    chk("R8 code frozen under hold", code, 131);
    chk("R8 alternation ignored under hold", lock, 0);
    hold = 1'b0;
    drive(1'b1, 1'b1);
    chk("R8 release resumes", code, 132);
  endtask

  task automatic t_sleep();
    int n, c;
    do_reset();
    repeat (5) drive(1'b1, 1'b1);
    sleep = 1'b1;
    repeat (10) drive(1'b1, 1'b1);
    chk("R9 code held in sleep", code, 133);
    sleep = 1'b0;
    drive(1'b1, 1'b1);
    chk("R9 wake restores code", code, 133);
    drive(1'b1, 1'b1);
    chk("R9 counting after wake", code, 134);
    do_reset();
    acquire(3000, n);
    c = code;
    sleep = 1'b1;
    repeat (8) drive(1'b1, 1'b0);
    sleep = 1'b0;
    drive(1'b1, 1'b0);
    chk("R9 lock kept across sleep", lock, 1);
    chk("R9 locked code kept across sleep", code, c);
    rst = 1'b1; drive(1'b0, 1'b0); rst = 1'b0;
    chk("R1 reset clears lock", lock, 0);
    chk("R1 reset reloads mid-scale", code, 128);
  endtask

  initial begin
    @(negedge clk);
    t_reset_and_step();
    t_saturate();
    t_acquire_and_unlock();
    t_acquire_low();
    t_hold();
    t_sleep();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule